// File: doc/BRIEF.md
# Configurable Pin Interrupt Controller

This block watches eight general-purpose input pins, arranged as two groups of four, and merges their events into one interrupt request. Each pin is enabled on its own, and each pin chooses whether its active sense is low or high. Each group chooses between two detection styles. In edge-only style a transition into the active sense latches the group's flag. In edge-plus-level style the flag also latches, and stays latched, for as long as any enabled pin of the group sits at its active level.

Software, or a neighbouring controller, programs the block through a single-cycle synchronous write port. A two-bit select picks the enable, mode, polarity or acknowledge target. The pins are asynchronous to the clock and are synchronized inside the block. The only outputs are the per-group flags and their combined request. Pad features such as pulls, slew rate and drive strength sit outside this block, as does power sequencing.

Top module: `pin_event_irq`

## Requirements
- R1: After reset both flags and the request are 0. All enables are 0, both groups are in edge-only style and all pins use falling/low sense. Enabling a pin with no further setup gives falling-edge detection.
- R2: A pin whose enable bit is 0 never affects any flag, whatever it does.
- R3: With polarity bit 0, a high-to-low pin change that reaches the pin before clock edge k sets the group flag after edge k+2 and not earlier. The group is pins 0-3 for flag bit 0 and pins 4-7 for flag bit 1.
- R4: With polarity bit 1, a low-to-high change sets the flag, and a high-to-low change does not.
- R5: In edge-only style, a pin that remains at its active level does not set the flag again after it has been acknowledged.
- R6: In edge-plus-level style (mode bit 1), an enabled pin at its active level sets the flag. An acknowledge cannot clear the flag while that pin stays active, and it does clear the flag once the pin is inactive.
- R7: A write with select 3 clears every flag whose bit in write data is 1, one cycle later. Flags whose bit is 0 are left unchanged.
- R8: If an edge is detected in the same cycle as the acknowledge of its group, the flag stays set.
- R9: A write with select 0 (enable, bit i = pin i), 1 (mode, bit g = group g) or 2 (polarity, bit i = pin i, 1 = rising/high) suppresses edge detection in the cycle that follows it. Later edges are detected normally.
- R10: The request output is 1 exactly when at least one flag is 1.
- R11: The groups are independent. Each group has its own mode bit and its own flag, and events of one group never set the other group's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Asynchronous pin levels |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_sel_i | input | 2 | Write target: 0 enable, 1 mode, 2 polarity, 3 acknowledge |
| wr_data_i | input | 8 | Write data |
| flag_o | output | 2 | Latched event flag per group |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The properties assume that a write strobe lasts a single cycle, that the select is always one of the four defined codes, and that the pins are free to change at any time because the synchronizer absorbs them. The stimulus changes pins and write fields only at the falling clock edge. It issues each write as a one-cycle pulse, and it times acknowledges and configuration writes against the known three-edge detection latency. This lets the coincident-acknowledge and masked-edge cases land on exactly the intended cycle.

// File: rtl/pie_pkg.sv
package pie_pkg;

    // Write target encoding on the configuration port
    typedef enum logic [1:0] {
        SEL_ENABLE   = 2'd0,
        SEL_MODE     = 2'd1,
        SEL_POLARITY = 2'd2,
        SEL_ACK      = 2'd3
    } wr_sel_e;

    localparam int SEL_W = 2;

endpackage

// File: rtl/pie_sync.sv
// Synchronizer chain plus one history stage for edge comparison.
module pie_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.chain[LAST];
    assign prev_o = st_q.prev;

endmodule

// File: rtl/pie_cfg.sv
// Configuration registers and the one-cycle edge mask after a change.
module pie_cfg
    import pie_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int NUM_GROUPS = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [SEL_W-1:0]      wr_sel_i,
    input  logic [NUM_PINS-1:0]   wr_data_i,
    output logic [NUM_PINS-1:0]   en_o,
    output logic [NUM_PINS-1:0]   pol_o,
    output logic [NUM_GROUPS-1:0] mode_o,
    output logic                  mask_o,
    output logic [NUM_GROUPS-1:0] ack_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0]   en;
        logic [NUM_PINS-1:0]   pol;
        logic [NUM_GROUPS-1:0] mode;
        logic                  mask;
    } cfg_t;

    cfg_t    cfg_d, cfg_q;
    wr_sel_e sel;

    always_comb begin
        sel        = wr_sel_e'(wr_sel_i);
        cfg_d      = cfg_q;
        cfg_d.mask = 1'b0;
        ack_o      = '0;
        if (wr_en_i) begin
            case (sel)
                SEL_ENABLE: begin
                    cfg_d.en   = wr_data_i;
                    cfg_d.mask = 1'b1;
                end
                SEL_MODE: begin
                    cfg_d.mode = wr_data_i[NUM_GROUPS-1:0];
                    cfg_d.mask = 1'b1;
                end
                SEL_POLARITY: begin
                    cfg_d.pol  = wr_data_i;
                    cfg_d.mask = 1'b1;
                end
                default: begin
                    ack_o = wr_data_i[NUM_GROUPS-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;   // disabled, edge-only, falling/low
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o   = cfg_q.en;
    assign pol_o  = cfg_q.pol;
    assign mode_o = cfg_q.mode;
    assign mask_o = cfg_q.mask;

endmodule

// File: rtl/pie_detect.sv
// Per-group event detection: edge hit and level hit.
module pie_detect #(
    parameter int PINS = 4
) (
    input  logic [PINS-1:0] cur_i,
    input  logic [PINS-1:0] prev_i,
    input  logic [PINS-1:0] en_i,
    input  logic [PINS-1:0] pol_i,
    input  logic            mode_i,
    input  logic            mask_i,
    output logic            edge_o,
    output logic            level_o
);

    logic [PINS-1:0] act_now;
    logic [PINS-1:0] act_old;
    logic [PINS-1:0] edge_hit;
    logic [PINS-1:0] lvl_hit;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        // active sense: polarity 1 means high is active
        assign act_now[p]  = ~(cur_i[p] ^ pol_i[p]);
        assign act_old[p]  = ~(prev_i[p] ^ pol_i[p]);
        assign edge_hit[p] = en_i[p] & act_now[p] & ~act_old[p];
        assign lvl_hit[p]  = en_i[p] & act_now[p];
    end

    assign edge_o  = ~mask_i & (|edge_hit);
    assign level_o = mode_i & (|lvl_hit);

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import pie_pkg::*;
#(
    parameter int NUM_GROUPS     = 2,
    parameter int PINS_PER_GROUP = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pins_i,
    input  logic                                 wr_en_i,
    input  logic [SEL_W-1:0]                     wr_sel_i,
    input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] wr_data_i,
    output logic [NUM_GROUPS-1:0]                flag_o,
    output logic                                 irq_o
);

    localparam int NUM_PINS = NUM_GROUPS * PINS_PER_GROUP;

    logic [NUM_PINS-1:0]   cur_w, prev_w;
    logic [NUM_PINS-1:0]   en_w, pol_w;
    logic [NUM_GROUPS-1:0] mode_w, ack_w;
    logic                  mask_w;
    logic [NUM_GROUPS-1:0] edge_w, level_w;

    pie_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (pins_i),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    pie_cfg #(
        .NUM_PINS   (NUM_PINS),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .en_o      (en_w),
        .pol_o     (pol_w),
        .mode_o    (mode_w),
        .mask_o    (mask_w),
        .ack_o     (ack_w)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        pie_detect #(
            .PINS (PINS_PER_GROUP)
        ) u_det (
            .cur_i   (cur_w [g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .prev_i  (prev_w[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .en_i    (en_w  [g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .pol_i   (pol_w [g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .mode_i  (mode_w[g]),
            .mask_i  (mask_w),
            .edge_o  (edge_w[g]),
            .level_o (level_w[g])
        );
    end

    typedef struct packed {
        logic [NUM_GROUPS-1:0] flag;
    } flag_t;

    flag_t fl_d, fl_q;

    // acknowledge clears, any new hit in the same cycle wins
    always_comb begin
        fl_d      = fl_q;
        fl_d.flag = (fl_q.flag & ~ack_w) | edge_w | level_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flag_o = fl_q.flag;
    assign irq_o  = |fl_q.flag;

endmodule

// File: rtl/pie_checker.sv
module pie_checker
    import pie_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int NUM_PINS   = 8
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  wr_en_i,
    input logic [SEL_W-1:0]      wr_sel_i,
    input logic [NUM_PINS-1:0]   wr_data_i,
    input logic [NUM_PINS-1:0]   en_w,
    input logic [NUM_GROUPS-1:0] mode_w,
    input logic                  mask_w,
    input logic [NUM_GROUPS-1:0] flag_o,
    input logic                  irq_o
);

    logic ack_all;
    assign ack_all = wr_en_i && (wr_sel_i == SEL_ACK)
                     && (wr_data_i[NUM_GROUPS-1:0] == '1);

    // R2: with no pin enabled a clear flag stays clear
    a_r2_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_w == '0 && flag_o == '0) |=> (flag_o == '0));

    // R7: a full acknowledge with nothing enabled empties every flag
    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_all && en_w == '0) |=> (flag_o == '0));

    // R9: the masked cycle after a config write produces no edge event
    a_r9_mask_blocks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_w && mode_w == '0 && flag_o == '0) |=> (flag_o == '0));

    // R10: request follows the flags
    a_r10_irq_tracks_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (flag_o != '0));

    // R5: a set flag persists until its own acknowledge
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hold
        a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_o[g] && !(wr_en_i && wr_sel_i == SEL_ACK && wr_data_i[g]))
            |=> flag_o[g]);
    end

endmodule

bind pin_event_irq pie_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_PINS   (NUM_PINS)
) i_pie_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .en_w      (en_w),
    .mode_w    (mode_w),
    .mask_w    (mask_w),
    .flag_o    (flag_o),
    .irq_o     (irq_o)
);

// File: tb/test_pin_event_irq.sv
`timescale 1ns/1ps
module test_pin_event_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] flag;
    logic       irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;   // 125 MHz

    pin_event_irq i_pin_event_irq (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pins_i    (pins),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .flag_o    (flag),
        .irq_o     (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] hist[$];
    logic [7:0] m_en, m_pol;
    logic [1:0] m_mode, m_flag;
    bit         m_mask;

    initial begin
        hist = '{8'h00, 8'h00, 8'h00};
        m_en = 0; m_pol = 0; m_mode = 0; m_flag = 0; m_mask = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{8'h00, 8'h00, 8'h00};
            m_en = 0; m_pol = 0; m_mode = 0; m_flag = 0; m_mask = 0;
        end else begin
            logic [7:0] now_v, old_v;
            logic [1:0] nf;
            now_v = hist[1];
            old_v = hist[2];
            for (int g = 0; g < 2; g++) begin
                nf[g] = m_flag[g];
                if (wr_en && wr_sel == 2'd3 && wr_data[g]) nf[g] = 1'b0;
                for (int p = 0; p < 4; p++) begin
                    int  i;
                    bit  a_now, a_old;
                    i     = g * 4 + p;
                    a_now = m_pol[i] ? now_v[i] : !now_v[i];
                    a_old = m_pol[i] ? old_v[i] : !old_v[i];
                    if (m_en[i] && !m_mask && a_now && !a_old) nf[g] = 1'b1;
                    if (m_en[i] && m_mode[g] && a_now) nf[g] = 1'b1;
                end
            end
            m_flag = nf;
            m_mask = 0;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin m_en = wr_data; m_mask = 1; end
                    2'd1: begin m_mode = wr_data[1:0]; m_mask = 1; end
                    2'd2: begin m_pol = wr_data; m_mask = 1; end
                    default: ;
                endcase
            end
            hist.push_front(pins);
            void'(hist.pop_back());
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (flag !== m_flag || irq !== (m_flag != 2'b00)) begin
                n_bad++;
                $display("FAIL %s model compare: flag=%b irq=%b expected flag=%b irq=%b",
                         cur_req, flag, irq, m_flag, (m_flag != 2'b00));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL %s watchdog expired", cur_req);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        cur_req = "R1";
        check("R1 reset flags", flag, 2'b00);
        check("R1 reset irq", {1'b0, irq}, 2'b00);

        pins = 8'hFF; step(4);
        cur_req = "R2";
        pins = 8'h00; step(2); pins = 8'hFF; step(4);
        check("R2 disabled pins ignored", flag, 2'b00);

        cur_req = "R3";
        do_write(2'd0, 8'h01); step(3);
        pins = 8'hFE; step(2);
        check("R3 no flag before latency", flag, 2'b00);
        step(1);
        check("R3 falling edge sets flag0 (R1 default falling)", flag, 2'b01);
        cur_req = "R10";
        check("R10 irq with flag", {1'b0, irq}, 2'b01);

        cur_req = "R7";
        do_write(2'd3, 8'h02);
        check("R7 other group ack keeps flag0", flag, 2'b01);
        do_write(2'd3, 8'h01);
        check("R7 ack clears flag0", flag, 2'b00);
        check("R10 irq drops", {1'b0, irq}, 2'b00);

        cur_req = "R5";
        step(5);
        check("R5 steady active level ignored in edge mode", flag, 2'b00);

        cur_req = "R4";
        do_write(2'd2, 8'h20); do_write(2'd0, 8'h21); step(3);
        pins = 8'hDE; step(5);
        check("R4 falling ignored with rising polarity", flag, 2'b00);
        pins = 8'hFE; step(4);
        check("R4 rising sets flag1 only (R11)", flag, 2'b10);
        do_write(2'd3, 8'h03); step(2);
        check("R4 cleared", flag, 2'b00);

        cur_req = "R6";
        do_write(2'd1, 8'h01); step(3);
        check("R6 level sets flag0", flag, 2'b01);
        do_write(2'd3, 8'h01);
        check("R6 ack blocked while level active", flag, 2'b01);
        pins = 8'hFF; step(4);
        do_write(2'd3, 8'h01);
        check("R6 ack clears after level gone", flag, 2'b00);
        do_write(2'd1, 8'h00); step(3);

        cur_req = "R8";
        pins = 8'hFE; step(2);
        do_write(2'd3, 8'h01);
        check("R8 edge beats coincident ack", flag, 2'b01);
        do_write(2'd3, 8'h01);
        check("R8 plain ack clears", flag, 2'b00);
        pins = 8'hFF; step(4);

        cur_req = "R9";
        do_write(2'd0, 8'h23); step(3);
        pins = 8'hFD; step(1);
        do_write(2'd2, 8'h20);
        step(4);
        check("R9 edge masked after config write", flag, 2'b00);
        pins = 8'hFF; step(4);
        pins = 8'hFD; step(4);
        check("R9 unmasked edge detected", flag, 2'b01);
        do_write(2'd3, 8'h03); pins = 8'hFF; step(4);

        cur_req = "R11";
        do_write(2'd1, 8'h02); step(3);
        check("R11 group1 level only", flag, 2'b10);
        do_write(2'd3, 8'h03);
        check("R11 group1 level holds, group0 clear", flag, 2'b10);
        do_write(2'd1, 8'h00);
        do_write(2'd3, 8'h03);
        check("R11 all cleared", flag, 2'b00);
        step(2);

        done = 1'b1;
        finish_run();
    end

endmodule